// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on to a ready state by driving its command pins through a fixed bring-up order. After reset it raises the clock enable and holds a no-operation command for a programmable settling period. It then closes all banks and issues a run of auto-refresh commands. After that it programs the mode register and, if enabled, the extended mode register. Every gap between two commands is a cycle count set by a parameter, and every cycle that carries no command drives a no-operation.

When the sequence completes, the block raises a ready flag and drops the data masks. From then on a refresh interval timer runs. It is reloaded from a period input given in clock cycles (the interval times the clock frequency, for example 781 at 100 MHz for 7.81 µs). When the timer expires it posts a refresh request, and the request stays up until the access logic acknowledges it. The access logic that later serves reads, writes and refreshes is a separate block. It watches the ready flag and the request.

Top module: `sdram_bringup`

## Requirements
- R1: While reset is held, cke is low, the command pins {cs_n,ras_n,cas_n,we_n} are 4'b1111, dqm is high, ba and addr are zero, and init_done and refresh_req are low. After reset is released, the first clock raises cke. The next T_STABLE cycles then carry NOP.
- R2: The first command after the settling period is precharge-all ({cs_n,ras_n,cas_n,we_n}=4'b0010) with addr bit PRE_BIT high, all other addr bits low and ba zero. The next command follows exactly T_RP cycles later.
- R3: Exactly N_REF auto-refresh commands (4'b0001, ba and addr zero) follow the precharge. Each one is followed exactly T_RC cycles later by the next command.
- R4: After the last refresh comes a mode register load (4'b0000) with ba zero and addr equal to mode_word. The next command or the ready state follows exactly T_MRD cycles later.
- R5: When ext_enable is high, the mode load is followed by an extended mode load (4'b0000) with ba equal to EXT_BA (default 2'b01) and addr equal to ext_mode_word, and then T_MRD cycles pass before the ready state. When ext_enable is low, this command is skipped and the ready state follows the mode load directly.
- R6: Every cycle of the sequence that carries no command drives NOP (4'b0111) with ba and addr zero, cke high and dqm high.
- R7: Once the sequence is complete, init_done is high and stays high, dqm is low, and the pins carry NOP until the next reset.
- R8: In the ready state the refresh timer expires every refresh_period cycles (a period of 1 expires every cycle). refresh_req rises in the cycle after each expiry. The first expiry falls in the refresh_period-th ready cycle.
- R9: refresh_req stays high until a cycle in which refresh_ack is high, and falls in the cycle after. If an expiry coincides with an acknowledge, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | ROW_W | Value placed on addr for the mode register load |
| ext_mode_word | input | ROW_W | Value placed on addr for the extended mode load |
| ext_enable | input | 1 | Issue the extended mode load |
| refresh_period | input | RP_W | Refresh interval in clock cycles |
| refresh_ack | input | 1 | Clears a pending refresh request |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | 1 | Data mask, high during bring-up |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Address bus |
| init_done | output | 1 | Device ready for normal accesses |
| refresh_req | output | 1 | Pending refresh request |

## Verification
The hardest situation to reach is an acknowledge that lands in the same cycle as a timer expiry. Before it can happen, the whole bring-up has to finish, and the collision then depends on the exact phase of the timer. The bench shortens the settling period through a parameter so that the ready state is reached quickly. It then holds refresh_ack high across more than one full period, so that at least one acknowledge lines up with an expiry whatever the phase. It repeats this with a period of one, where every ready cycle is an expiry.

// File: rtl/sdram_bringup.sv
module sdram_bringup #(
  parameter int T_STABLE = 20000,
  parameter int T_RP     = 3,
  parameter int T_RC     = 9,
  parameter int T_MRD    = 2,
  parameter int N_REF    = 8,
  parameter int ROW_W    = 13,
  parameter int BANK_W   = 2,
  parameter int PRE_BIT  = 10,
  parameter int RP_W     = 16,
  parameter logic [BANK_W-1:0] EXT_BA = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  mode_word,
  input  logic [ROW_W-1:0]  ext_mode_word,
  input  logic              ext_enable,
  input  logic [RP_W-1:0]   refresh_period,
  input  logic              refresh_ack,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              dqm,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic              init_done,
  output logic              refresh_req
);

  localparam int GMAX1  = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int GMAX2  = (GMAX1 > T_MRD) ? GMAX1 : T_MRD;
  localparam int GMAX   = (GMAX2 > T_STABLE) ? GMAX2 : T_STABLE;
  localparam int GAP_W  = $clog2(GMAX + 1);
  localparam int NREF_W = $clog2(N_REF + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_PRE, ST_PRE_GAP, ST_REF, ST_REF_GAP,
    ST_LMR, ST_LMR_GAP, ST_EMR, ST_EMR_GAP, ST_RUN
  } state_t;

  state_t state, state_d;
  logic [GAP_W-1:0]  gap, gap_d;
  logic [NREF_W-1:0] nref;
  logic [RP_W-1:0]   rcnt;
  logic [3:0]        cmd;
  logic              go_run, tick;

  always_comb begin
    state_d = state;
    gap_d   = gap;
    case (state)
      ST_IDLE: begin
        state_d = ST_WAIT;
        gap_d   = GAP_W'(T_STABLE - 1);
      end
      ST_WAIT:
        if (gap == 0) state_d = ST_PRE;
        else gap_d = gap - 1'b1;
      ST_PRE:
        if (T_RP > 1) begin
          state_d = ST_PRE_GAP;
          gap_d   = GAP_W'(T_RP - 2);
        end else state_d = ST_REF;
      ST_PRE_GAP:
        if (gap == 0) state_d = ST_REF;
        else gap_d = gap - 1'b1;
      ST_REF:
        if (T_RC > 1) begin
          state_d = ST_REF_GAP;
          gap_d   = GAP_W'(T_RC - 2);
        end else state_d = (nref == NREF_W'(N_REF - 1)) ? ST_LMR : ST_REF;
      ST_REF_GAP:
        if (gap == 0) state_d = (nref == NREF_W'(N_REF)) ? ST_LMR : ST_REF;
        else gap_d = gap - 1'b1;
      ST_LMR:
        if (T_MRD > 1) begin
          state_d = ST_LMR_GAP;
          gap_d   = GAP_W'(T_MRD - 2);
        end else state_d = ext_enable ? ST_EMR : ST_RUN;
      ST_LMR_GAP:
        if (gap == 0) state_d = ext_enable ? ST_EMR : ST_RUN;
        else gap_d = gap - 1'b1;
      ST_EMR:
        if (T_MRD > 1) begin
          state_d = ST_EMR_GAP;
          gap_d   = GAP_W'(T_MRD - 2);
        end else state_d = ST_RUN;
      ST_EMR_GAP:
        if (gap == 0) state_d = ST_RUN;
        else gap_d = gap - 1'b1;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      gap   <= '0;
      nref  <= '0;
    end else begin
      state <= state_d;
      gap   <= gap_d;
      if (state == ST_REF) nref <= nref + 1'b1;
    end
  end

  assign go_run = (state_d == ST_RUN) && (state != ST_RUN);
  assign tick   = (state == ST_RUN) && (rcnt == 0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt        <= '0;
      refresh_req <= 1'b0;
    end else begin
      if (go_run || tick) rcnt <= refresh_period - 1'b1;
      else if (state == ST_RUN) rcnt <= rcnt - 1'b1;
      refresh_req <= tick | (refresh_req & ~refresh_ack);
    end
  end

  always_comb begin
    cmd  = C_NOP;
    ba   = '0;
    addr = '0;
    case (state)
      ST_IDLE: cmd = C_DES;
      ST_PRE: begin
        cmd = C_PRE;
        addr[PRE_BIT] = 1'b1;
      end
      ST_REF: cmd = C_REF;
      ST_LMR: begin
        cmd  = C_MRS;
        addr = mode_word;
      end
      ST_EMR: begin
        cmd  = C_MRS;
        ba   = EXT_BA;
        addr = ext_mode_word;
      end
      default: cmd = C_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = (state != ST_IDLE);
  assign dqm       = (state != ST_RUN);
  assign init_done = (state == ST_RUN);

  // Spacing checker: cycles since the last command seen on the pins.
  localparam int CHK_W = GAP_W + 1;
  logic [CHK_W-1:0] chk_since;
  logic [3:0]       chk_last;
  logic [7:0]       chk_refs;
  logic             pin_cmd;
  logic [3:0]       pin_code;

  assign pin_code = {cs_n, ras_n, cas_n, we_n};
  assign pin_cmd  = !cs_n && (!ras_n || !cas_n || !we_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_since <= '0;
      chk_last  <= C_NOP;
      chk_refs  <= '0;
    end else if (pin_cmd) begin
      chk_since <= CHK_W'(1);
      chk_last  <= pin_code;
      if (pin_code == C_REF) chk_refs <= chk_refs + 1'b1;
    end else if (chk_since != '1) begin
      chk_since <= chk_since + 1'b1;
    end
  end

  p_settle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd && chk_last == C_NOP) |-> (cke && chk_since >= CHK_W'(T_STABLE)));
  p_pre_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd && pin_code == C_PRE) |-> (addr[PRE_BIT] && chk_last == C_NOP));
  p_rp_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd && chk_last == C_PRE) |-> (chk_since >= CHK_W'(T_RP)));
  p_rc_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd && chk_last == C_REF) |-> (chk_since >= CHK_W'(T_RC)));
  p_ref_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd && pin_code == C_MRS && ba == '0) |-> (chk_refs == 8'(N_REF)));
  p_mrd_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd && chk_last == C_MRS) |-> (chk_since >= CHK_W'(T_MRD)));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> refresh_req);

endmodule

// File: tb/sdram_bringup_test.sv
`timescale 1ns/1ps
module sdram_bringup_test;
  localparam int TS = 40, TRP = 3, TRC = 4, TMRD = 2, NREF = 8;
  localparam int ROW_W = 13, BANK_W = 2, RP_W = 16;

  logic clk = 0, rst_n = 0;
  logic [ROW_W-1:0] mode_word = '0, ext_mode_word = '0;
  logic ext_enable = 0, refresh_ack = 0;
  logic [RP_W-1:0] refresh_period = 16'd7;
  logic cke, cs_n, ras_n, cas_n, we_n, dqm, init_done, refresh_req;
  logic [BANK_W-1:0] ba;
  logic [ROW_W-1:0] addr;

  sdram_bringup #(.T_STABLE(TS), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .N_REF(NREF),
                  .ROW_W(ROW_W), .BANK_W(BANK_W), .PRE_BIT(10), .RP_W(RP_W), .EXT_BA(2'b01)) uut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .ext_mode_word(ext_mode_word),
    .ext_enable(ext_enable), .refresh_period(refresh_period), .refresh_ack(refresh_ack),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dqm(dqm),
    .ba(ba), .addr(addr), .init_done(init_done), .refresh_req(refresh_req));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit active = 0, finished = 0;
  logic [21:0] exp_q[$];
  int tag_q[$];
  int run_k = 0, cur_per = 1;
  bit model_req = 0, prev_ack = 0;

  function automatic logic [21:0] vec(logic k, logic [3:0] c, logic m,
                                      logic [1:0] b, logic [12:0] a, logic d);
    return {k, c, m, b, a, d};
  endfunction

  task automatic push(logic [21:0] v, int tag, int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  always @(negedge clk) begin
    if (active) begin
      logic [21:0] got, want;
      int tag;
      bit in_run, tk;
      got = {cke, cs_n, ras_n, cas_n, we_n, dqm, ba, addr, init_done};
      in_run = (exp_q.size() == 0);
      if (!in_run) begin
        want = exp_q.pop_front();
        tag  = tag_q.pop_front();
      end else begin
        want = vec(1, 4'b0111, 0, 2'b00, '0, 1); // R7 ready state
        tag  = 7;
      end
      checks++;
      if (got !== want) begin
        errors++;
        $display("FAIL R%0d pins got %h expected %h", tag, got, want);
      end
      checks++;
      if (refresh_req !== model_req) begin
        errors++;
        $display("FAIL R%0d refresh_req got %b expected %b", prev_ack ? 9 : 8,
                 refresh_req, model_req);
      end
      tk = in_run && ((run_k % cur_per) == cur_per - 1); // R8 expiry cycle
      if (in_run) run_k++;
      model_req = tk ? 1'b1 : (refresh_ack ? 1'b0 : model_req); // R9
      prev_ack = refresh_ack;
    end
  end

  task automatic run_case(bit ext, logic [12:0] mw, logic [12:0] emw, int per);
    rst_n = 0;
    active = 0;
    ext_enable = ext;
    mode_word = mw;
    ext_mode_word = emw;
    refresh_period = RP_W'(per);
    refresh_ack = 0;
    cur_per = per;
    repeat (3) @(posedge clk);
    exp_q.delete();
    tag_q.delete();
    push(vec(0, 4'b1111, 1, 2'b00, '0, 0), 1, 1);           // R1 reset state
    push(vec(1, 4'b0111, 1, 2'b00, '0, 0), 1, TS);          // R1 settle
    push(vec(1, 4'b0010, 1, 2'b00, 13'h0400, 0), 2, 1);     // R2 precharge all
    push(vec(1, 4'b0111, 1, 2'b00, '0, 0), 6, TRP - 1);     // R6
    for (int r = 0; r < NREF; r++) begin
      push(vec(1, 4'b0001, 1, 2'b00, '0, 0), 3, 1);         // R3
      push(vec(1, 4'b0111, 1, 2'b00, '0, 0), 6, TRC - 1);
    end
    push(vec(1, 4'b0000, 1, 2'b00, mw, 0), 4, 1);           // R4
    push(vec(1, 4'b0111, 1, 2'b00, '0, 0), 6, TMRD - 1);
    if (ext) begin
      push(vec(1, 4'b0000, 1, 2'b01, emw, 0), 5, 1);        // R5
      push(vec(1, 4'b0111, 1, 2'b00, '0, 0), 6, TMRD - 1);
    end
    model_req = 0;
    prev_ack = 0;
    run_k = 0;
    @(negedge clk);
    checks++; // R1 while reset is held
    if (cke !== 1'b0 || init_done !== 1'b0 || refresh_req !== 1'b0 || cs_n !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset got cke=%b done=%b req=%b cs_n=%b expected 0 0 0 1",
               cke, init_done, refresh_req, cs_n);
    end
    @(posedge clk);
    #1 rst_n = 1;
    active = 1;
    while (exp_q.size() > 0) @(posedge clk);
    repeat (3 * per + 2) @(posedge clk);
    #1 refresh_ack = 1;           // single acknowledge, R9
    @(posedge clk);
    #1 refresh_ack = 0;
    repeat (per + 3) @(posedge clk);
    #1 refresh_ack = 1;           // hold across an expiry, R9
    repeat (2 * per + 2) @(posedge clk);
    #1 refresh_ack = 0;
    repeat (per + 2) @(posedge clk);
    #1 active = 0;
  endtask

  initial begin
    run_case(1, 13'h0033, 13'h0020, 7);
    run_case(0, 13'h0027, 13'h1fff, 4);
    run_case(1, 13'h1a5a, 13'h0001, 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule